// File: doc/BRIEF.md
# Deferred Transaction ID Allocator

This block hands out and tracks 8-bit deferred identifiers for the outstanding deferrable requests of a single bus agent. Each identifier joins three fields: an agent-class bit (0 for a symmetric agent, 1 for a priority agent), the agent's 3-bit ID, and a 4-bit transaction number. The transaction number comes from a pool of 16. A number stays reserved for as long as its transaction might still be deferred, so no two live requests of the agent ever share one.

A deferrable request takes the lowest free number in the cycle it is presented. The identifier appears at once on the output with a valid flag. Accepted requests wait in an in-order queue for their snoop result, and each snoop result applies to the oldest waiting request. If the snoop result does not defer, the number goes back to the pool. If it defers, the number is parked until a deferred reply carries this agent's class bit, agent ID and that exact number. A reply that matches nothing is dropped and raises a one-cycle error pulse.

Top module: `dtag_alloc`

## Requirements
- R1: The identifier on `id_out` is formed as bit 7 = `agent_prio`, bits 6:4 = `agent_id`, bits 3:0 = transaction number. A symmetric agent (`agent_prio`=0) therefore gives bit 7 = 0 and a priority agent gives bit 7 = 1.
- R2: When `req_valid` and `req_defer_en` are high and a number is free, `id_valid` is high in that same cycle, and `id_out` carries the lowest-numbered free transaction number.
- R3: A granted number is never one already in use. It is reserved from the next clock edge on.
- R4: A request with `req_defer_en` low keeps `id_valid` low and reserves no number.
- R5: `pool_full` is high exactly when all 16 numbers are reserved. While it is high, deferrable requests are refused (`id_valid` low).
- R6: A snoop result with `snoop_defer` low releases the number of the request it applies to. That number can be granted again from the next cycle.
- R7: Snoop results apply to the accepted deferrable requests strictly in the order the requests were accepted.
- R8: A snoop result with `snoop_defer` high keeps the number reserved. It stays reserved until a reply whose bits 7:4 equal {`agent_prio`,`agent_id`} and whose bits 3:0 equal that number. Such a reply releases it and raises no error.
- R9: A reply whose bits 7:4 differ from {`agent_prio`,`agent_id`} changes no state. It raises `reply_err` for exactly one cycle, on the cycle after the reply.
- R10: A reply addressed to this agent whose number is not parked by a deferring snoop changes no state and raises the same one-cycle `reply_err` pulse.
- R11: Reset releases every number and empties the snoop-order queue.
- R12: A snoop result that arrives while no accepted request is waiting for one is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| agent_prio | input | 1 | Agent class: 0 symmetric, 1 priority |
| agent_id | input | 3 | This agent's ID |
| req_valid | input | 1 | A request is issued this cycle |
| req_defer_en | input | 1 | The request may be deferred |
| snoop_valid | input | 1 | Snoop result for the oldest waiting request |
| snoop_defer | input | 1 | Snoop result says the transaction is deferred |
| reply_valid | input | 1 | A deferred reply is seen this cycle |
| reply_id | input | 8 | Identifier carried by the deferred reply |
| id_out | output | 8 | Identifier for the current request |
| id_valid | output | 1 | A number was granted to the current request |
| pool_full | output | 1 | All transaction numbers are reserved |
| reply_err | output | 1 | One-cycle pulse after an unmatched reply |

## Verification
The hardest state to reach is a pool with reserved numbers in every life stage at once: some waiting for a snoop result, some parked after a deferring snoop, and some released out of allocation order. From that mix, a wrong queue head or a wrong release shows up only as a different number granted later. The stimulus builds this with directed tasks that interleave grants, non-deferring snoops and deferring snoops. It then probes the parked numbers with foreign-agent replies and with replies to numbers still waiting. After that it fills the remaining pool to the full condition and frees a single number through the queue head. Each step's effect is read from the next granted number.

// File: rtl/dtag_pkg.sv
package dtag_pkg;
  localparam int TNUM_W  = 4;
  localparam int AGENT_W = 3;
  localparam int ID_W    = 1 + AGENT_W + TNUM_W;

  typedef struct packed {
    logic               prio;
    logic [AGENT_W-1:0] agent;
    logic [TNUM_W-1:0]  num;
  } dtag_t;

  function automatic dtag_t dtag_make(input logic prio,
                                      input logic [AGENT_W-1:0] agent,
                                      input logic [TNUM_W-1:0] num);
    dtag_t t;
    t.prio  = prio;
    t.agent = agent;
    t.num   = num;
    return t;
  endfunction
endpackage

// File: rtl/dtag_pick.sv
module dtag_pick #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  busy,
  output logic          any_free,
  output logic [IW-1:0] idx
);
  always_comb begin
    any_free = 1'b0;
    idx      = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        any_free = 1'b1;
        idx      = IW'(i);
      end
    end
  end
endmodule

// File: rtl/dtag_order_q.sv
module dtag_order_q #(
  parameter int W     = 4,
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign empty = (cnt == '0);
endmodule

// File: rtl/dtag_reply_match.sv
module dtag_reply_match
  import dtag_pkg::*;
#(
  parameter int N = 16
) (
  input  logic               reply_valid,
  input  dtag_t              reply_tag,
  input  logic               self_prio,
  input  logic [AGENT_W-1:0] self_agent,
  input  logic [N-1:0]       parked,
  output logic               hit,
  output logic               miss,
  output logic [TNUM_W-1:0]  hit_num
);
  logic own;

  assign own     = (reply_tag.prio == self_prio) && (reply_tag.agent == self_agent);
  assign hit_num = reply_tag.num;
  assign hit     = reply_valid && own && parked[reply_tag.num];
  assign miss    = reply_valid && !hit;
endmodule

// File: rtl/dtag_alloc.sv
module dtag_alloc
  import dtag_pkg::*;
#(
  parameter int QDEPTH = 1 << dtag_pkg::TNUM_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               agent_prio,
  input  logic [AGENT_W-1:0] agent_id,
  input  logic               req_valid,
  input  logic               req_defer_en,
  input  logic               snoop_valid,
  input  logic               snoop_defer,
  input  logic               reply_valid,
  input  logic [ID_W-1:0]    reply_id,
  output logic [ID_W-1:0]    id_out,
  output logic               id_valid,
  output logic               pool_full,
  output logic               reply_err
);
  localparam int NTAG = 1 << TNUM_W;

  function automatic logic [NTAG-1:0] num_mask(input logic en, input logic [TNUM_W-1:0] n);
    logic [NTAG-1:0] m;
    m    = '0;
    m[n] = en;
    return m;
  endfunction

  logic [NTAG-1:0]   busy_q, parked_q;
  logic              any_free;
  logic [TNUM_W-1:0] free_idx;
  logic [TNUM_W-1:0] q_head;
  logic              q_empty;
  logic              ev_grant, ev_snoop_take, ev_snoop_release, ev_snoop_park;
  logic              ev_reply_hit, ev_reply_miss;
  logic [TNUM_W-1:0] reply_num;
  logic              reply_err_q;

  dtag_pick #(.N(NTAG)) u_pick (
    .busy     (busy_q),
    .any_free (any_free),
    .idx      (free_idx)
  );

  assign ev_grant         = req_valid && req_defer_en && any_free;
  assign ev_snoop_take    = snoop_valid && !q_empty;
  assign ev_snoop_release = ev_snoop_take && !snoop_defer;
  assign ev_snoop_park    = ev_snoop_take && snoop_defer;

  dtag_order_q #(.W(TNUM_W), .DEPTH(QDEPTH)) u_order (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ev_grant),
    .push_data (free_idx),
    .pop       (ev_snoop_take),
    .head      (q_head),
    .empty     (q_empty)
  );

  dtag_reply_match #(.N(NTAG)) u_match (
    .reply_valid (reply_valid),
    .reply_tag   (dtag_t'(reply_id)),
    .self_prio   (agent_prio),
    .self_agent  (agent_id),
    .parked      (parked_q),
    .hit         (ev_reply_hit),
    .miss        (ev_reply_miss),
    .hit_num     (reply_num)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q      <= '0;
      parked_q    <= '0;
      reply_err_q <= 1'b0;
    end else begin
      busy_q <= (busy_q | num_mask(ev_grant, free_idx))
              & ~num_mask(ev_snoop_release, q_head)
              & ~num_mask(ev_reply_hit, reply_num);
      parked_q <= (parked_q | num_mask(ev_snoop_park, q_head))
                & ~num_mask(ev_reply_hit, reply_num);
      reply_err_q <= ev_reply_miss;
    end
  end

  assign id_out    = dtag_make(agent_prio, agent_id, free_idx);
  assign id_valid  = ev_grant;
  assign pool_full = !any_free;
  assign reply_err = reply_err_q;
endmodule

// File: rtl/dtag_alloc_chk.sv
module dtag_alloc_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         agent_prio,
  input logic [2:0]   agent_id,
  input logic         req_valid,
  input logic         req_defer_en,
  input logic         reply_valid,
  input logic [7:0]   reply_id,
  input logic [7:0]   id_out,
  input logic         id_valid,
  input logic         pool_full,
  input logic         reply_err,
  input logic [N-1:0] busy_q,
  input logic [N-1:0] parked_q
);
  a_r1_fields: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |-> (id_out[7:4] == {agent_prio, agent_id}));

  a_r3_unused_num: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |-> !busy_q[id_out[3:0]]);

  a_r3_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> busy_q[$past(id_out[3:0])]);

  a_r4_nondefer: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_defer_en) |-> !id_valid);

  a_r5_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    pool_full |-> !id_valid);

  a_r5_all_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pool_full |-> (&busy_q));

  a_r8_parked_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !reply_valid |=> ((parked_q & $past(parked_q)) == $past(parked_q)));

  a_r8_reply_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_valid && reply_id[7:4] == {agent_prio, agent_id} && parked_q[reply_id[3:0]])
      |=> (!reply_err && !busy_q[$past(reply_id[3:0])]));

  a_r9_foreign_err: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_valid && reply_id[7:4] != {agent_prio, agent_id}) |=> reply_err);

  a_r10_unparked_err: assert property (@(posedge clk) disable iff (!rst_n)
    (reply_valid && reply_id[7:4] == {agent_prio, agent_id} && !parked_q[reply_id[3:0]])
      |=> reply_err);
endmodule

bind dtag_alloc dtag_alloc_chk #(.N(16)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .agent_prio   (agent_prio),
  .agent_id     (agent_id),
  .req_valid    (req_valid),
  .req_defer_en (req_defer_en),
  .reply_valid  (reply_valid),
  .reply_id     (reply_id),
  .id_out       (id_out),
  .id_valid     (id_valid),
  .pool_full    (pool_full),
  .reply_err    (reply_err),
  .busy_q       (busy_q),
  .parked_q     (parked_q)
);

// File: tb/test_dtag_alloc.sv
module test_dtag_alloc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       agent_prio = 1'b1;
  logic [2:0] agent_id = 3'd5;
  logic       req_valid = 1'b0, req_defer_en = 1'b0;
  logic       snoop_valid = 1'b0, snoop_defer = 1'b0;
  logic       reply_valid = 1'b0;
  logic [7:0] reply_id = 8'h00;
  logic [7:0] id_out;
  logic       id_valid, pool_full, reply_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  dtag_alloc i_dtag_alloc (
    .clk (clk), .rst_n (rst_n), .agent_prio (agent_prio), .agent_id (agent_id),
    .req_valid (req_valid), .req_defer_en (req_defer_en),
    .snoop_valid (snoop_valid), .snoop_defer (snoop_defer),
    .reply_valid (reply_valid), .reply_id (reply_id),
    .id_out (id_out), .id_valid (id_valid), .pool_full (pool_full), .reply_err (reply_err)
  );

  function automatic int expect_id(int num);
    return int'(agent_prio) * 128 + int'(agent_id) * 16 + num;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(bit ok, string rq, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic req(bit den, bit exp_v, int exp_num, string rq);
    req_valid = 1'b1;
    req_defer_en = den;
    #1;
    chk(id_valid == exp_v, {rq, " id_valid"}, int'(id_valid), int'(exp_v));
    if (exp_v) chk(id_out == 8'(expect_id(exp_num)), {rq, " id_out"}, int'(id_out), expect_id(exp_num));
    tick();
    req_valid = 1'b0;
    req_defer_en = 1'b0;
  endtask

  task automatic snoop(bit dfr);
    snoop_valid = 1'b1;
    snoop_defer = dfr;
    tick();
    snoop_valid = 1'b0;
    snoop_defer = 1'b0;
  endtask

  task automatic reply(int rid, bit exp_err, string rq);
    reply_valid = 1'b1;
    reply_id = 8'(rid);
    tick();
    reply_valid = 1'b0;
    chk(reply_err == exp_err, {rq, " reply_err"}, int'(reply_err), int'(exp_err));
    tick();
    chk(reply_err == 1'b0, {rq, " reply_err one cycle"}, int'(reply_err), 0);
  endtask

  task automatic do_reset(bit prio, int aid);
    rst_n = 1'b0;
    agent_prio = prio;
    agent_id = 3'(aid);
    tick();
    tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_reset_state();
    chk(pool_full == 1'b0, "R11 pool empty after reset", int'(pool_full), 0);
    chk(reply_err == 1'b0, "R11 no error after reset", int'(reply_err), 0);
    chk(id_valid == 1'b0, "R11 no grant without request", int'(id_valid), 0);
  endtask

  task automatic t_alloc_order();
    req(1'b1, 1'b1, 0, "R1 R2 first grant");
    req(1'b1, 1'b1, 1, "R2 second grant");
    req(1'b1, 1'b1, 2, "R2 R3 third grant");
  endtask

  task automatic t_nondefer();
    req(1'b0, 1'b0, 0, "R4 nondeferrable refused a number");
    req(1'b1, 1'b1, 3, "R4 no number consumed");
  endtask

  task automatic t_snoop_order();
    snoop(1'b0);
    req(1'b1, 1'b1, 0, "R6 released number reused");
    snoop(1'b1);
    snoop(1'b0);
    req(1'b1, 1'b1, 2, "R7 in-order snoop release");
  endtask

  task automatic t_bad_replies();
    reply(8'h51, 1'b1, "R9 foreign agent class");
    req(1'b1, 1'b1, 4, "R9 parked number untouched");
    reply(8'hD3, 1'b1, "R10 reply to unparked number");
    req(1'b1, 1'b1, 5, "R10 waiting number untouched");
  endtask

  task automatic t_good_reply();
    reply(8'hD1, 1'b0, "R8 matching reply");
    req(1'b1, 1'b1, 1, "R8 reply released number");
  endtask

  task automatic t_fill();
    for (int n = 6; n < 16; n++) req(1'b1, 1'b1, n, "R2 fill pool");
    chk(pool_full == 1'b1, "R5 full flag", int'(pool_full), 1);
    req(1'b1, 1'b0, 0, "R5 refused when full");
    snoop(1'b0);
    chk(pool_full == 1'b0, "R5 full clears after release", int'(pool_full), 0);
    req(1'b1, 1'b1, 3, "R6 R7 oldest waiting released");
  endtask

  task automatic t_empty_snoop();
    do_reset(1'b0, 2);
    chk(pool_full == 1'b0, "R11 reset releases all", int'(pool_full), 0);
    snoop(1'b0);
    req(1'b1, 1'b1, 0, "R12 R1 symmetric agent grant");
    snoop(1'b1);
    reply(8'h20, 1'b0, "R12 snoop applied to real request");
    req(1'b1, 1'b1, 0, "R8 R11 number back after reply");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1, 5);
    t_reset_state();
    t_alloc_order();
    t_nondefer();
    t_snoop_order();
    t_bad_replies();
    t_good_reply();
    t_fill();
    t_empty_snoop();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule